// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands and returns a 64-bit product as an upper word and a lower word. It computes one partial product per clock and reuses a single 32-bit adder for every step. The multiplier operand sits in the low half of a 64-bit accumulator register. On each step the multiplicand is added into the high half when the accumulator's bit 0 is set. The whole register then moves one place toward bit 0, and the adder carry enters at the top.

A caller drives the operands and a signed/unsigned select, then pulses `start` for one cycle while the block is idle. `busy` stays high during the step cycles. `done` pulses when the product is ready. In signed mode the block works on the operand magnitudes. It negates the 64-bit result when exactly one operand is negative.

Top module: `seq_mul`

## Requirements
- R1: With `signedMode`=0, {`hi`,`lo`} equals the unsigned 64-bit product of `opA` and `opB` when `done` is high.
- R2: With `signedMode`=1, {`hi`,`lo`} equals the two's-complement 64-bit product of `opA` and `opB` read as signed values, including the most negative operand.
- R3: A start is accepted on the clock edge where `start`=1 and `busy`=0. `busy` is then high for exactly 32 cycles. On the edge where `busy` falls, `done` rises, and it stays high for one cycle only.
- R4: A `start` that arrives while `busy`=1 is ignored. The running product, its operands and its timing are unaffected, and no extra `done` pulse follows.
- R5: While idle and without an accepted start, `hi` and `lo` keep the last product.
- R6: After reset, `busy`, `done`, `hi` and `lo` are all 0.
- R7: The adder carry is kept in the product. For example, 0xFFFFFFFF times 0xFFFFFFFF unsigned gives `hi`=0xFFFFFFFE and `lo`=0x00000001.
- R8: Small products come out exact, for example 6 times 5 gives `hi`=0 and `lo`=30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply; honoured only while idle |
| signedMode | input | 1 | 1 = treat operands as two's complement, 0 = unsigned |
| opA | input | 32 | Multiplicand, sampled at an accepted start |
| opB | input | 32 | Multiplier, sampled at an accepted start |
| busy | output | 1 | High during the 32 step cycles |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | 32 | Upper word of the product |
| lo | output | 32 | Lower word of the product |

## Verification
Several properties are checked on every cycle. `done` lasts one cycle and coincides with the fall of `busy`. The run length is exactly 32 cycles. A start during a run does not restart the step count. The result words stay still while the block is idle. Arithmetic correctness can only be shown by the bench scenarios, which compare unsigned and signed products against values computed independently. Those scenarios cover the full-scale carry case, the most negative operand and mixed signs, plus a start pulse injected in the middle of a run.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } mulCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulState_t;
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output mulCtrl_t ctrlS,
  output logic     busy,
  output logic     done
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam int LEN_W = $clog2(WIDTH + 1) + 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  mulState_t      state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    ctrlS.load = start && (state == ST_IDLE);
    ctrlS.step = (state == ST_RUN);
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ctrlS.load) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST_STEP) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent run-length counter used only by the checks below
  logic [LEN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            runLen <= '0;
    else if (ctrlS.load)  runLen <= '0;
    else if (busy)        runLen <= runLen + 1'b1;
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_run_length_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == LEN_W'(WIDTH)));

  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && runLen != '0) |=> (!busy || runLen == $past(runLen) + 1'b1));
endmodule

// File: rtl/seq_mul_dpath.sv
module seq_mul_dpath
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulCtrl_t           ctrlS,
  input  logic               signedMode,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [WIDTH-1:0]   hiWord,
  output logic [WIDTH-1:0]   loWord
);
  localparam int PROD_W = 2 * WIDTH;

  logic [WIDTH-1:0]  mcand;
  logic [PROD_W-1:0] prodReg;
  logic              negFlag;

  logic              aNeg, bNeg;
  logic [WIDTH-1:0]  magA, magB;
  logic [WIDTH:0]    sumWide;
  logic [WIDTH-1:0]  addend;
  logic [PROD_W-1:0] result;

  always_comb begin
    aNeg = signedMode && opA[WIDTH-1];
    bNeg = signedMode && opB[WIDTH-1];
    magA = aNeg ? (~opA + 1'b1) : opA;
    magB = bNeg ? (~opB + 1'b1) : opB;
    addend  = prodReg[0] ? mcand : '0;
    sumWide = {1'b0, prodReg[PROD_W-1:WIDTH]} + {1'b0, addend};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      prodReg <= '0;
      negFlag <= 1'b0;
    end else if (ctrlS.load) begin
      mcand   <= magA;
      prodReg <= {{WIDTH{1'b0}}, magB};
      negFlag <= aNeg ^ bNeg;
    end else if (ctrlS.step) begin
      prodReg <= {sumWide, prodReg[WIDTH-1:1]};
    end
  end

  assign result = negFlag ? (~prodReg + 1'b1) : prodReg;
  assign hiWord = result[PROD_W-1:WIDTH];
  assign loWord = result[WIDTH-1:0];
endmodule

// File: rtl/seq_mul.sv
module seq_mul
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  mulCtrl_t ctrlS;

  seq_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrlS (ctrlS),
    .busy  (busy),
    .done  (done)
  );

  seq_mul_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlS      (ctrlS),
    .signedMode (signedMode),
    .opA        (opA),
    .opB        (opB),
    .hiWord     (hi),
    .loWord     (lo)
  );

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable({hi, lo}));
endmodule

// File: tb/sim_seq_mul.sv
module sim_seq_mul;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int RUN_CYC = 32;

  typedef struct packed {
    logic [2*W-1:0] prod;
    int unsigned    dueCyc;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         busy, done;
  logic [W-1:0] hi, lo;

  int unsigned cyc = 0;
  int total = 0;
  int bad = 0;
  int busyLen = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  seq_mul #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] refProd(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn);
    longint sa, sb;
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  // Driver: issue one multiply and push its expected result
  task automatic doOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit sgn);
    expItem_t it;
    while (busy) @(negedge clk);
    opA = a; opB = b; signedMode = sgn; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    it.prod   = refProd(a, b, sgn);
    it.dueCyc = cyc + RUN_CYC;
    expQ.push_back(it);
  endtask

  // Monitor: pops expected items as done pulses appear
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyLen++;
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected done", 64'd1, 64'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          // R1 R2 R7 R8 product value
          check({hi, lo} == it.prod, "R1/R2 product", {hi, lo}, it.prod);
          check(cyc == it.dueCyc, "R3 done timing", 64'(cyc), 64'(it.dueCyc));
          check(busyLen == RUN_CYC, "R3 busy length", 64'(busyLen), 64'(RUN_CYC));
        end
        busyLen = 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R6 reset state
    check(busy == 1'b0 && done == 1'b0, "R6 reset flags", {busy, done}, 64'd0);
    check({hi, lo} == 64'd0, "R6 reset product", {hi, lo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    doOp(32'd6, 32'd5, 1'b0);                     // R8
    doOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);     // R7
    doOp(32'h1234_5678, 32'h9ABC_DEF0, 1'b0);     // R1
    doOp(32'd0, 32'hDEAD_BEEF, 1'b0);             // R1 zero
    doOp(32'hFFFF_FFFF, 32'd1, 1'b1);             // R2 -1*1
    doOp(32'h8000_0000, 32'h8000_0000, 1'b1);     // R2 most negative squared
    doOp(32'h8000_0000, 32'd1, 1'b1);             // R2
    doOp(32'hFFFF_FFF9, 32'd123_456, 1'b1);       // R2 mixed signs
    doOp(32'hFFFF_FFFD, 32'hFFFF_FFFB, 1'b1);     // R2 both negative
    doOp(32'h8000_0000, 32'h8000_0000, 1'b0);     // R1 same bits unsigned

    // R4: second start mid-run is ignored
    doOp(32'd1000, 32'd77, 1'b0);
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R4 busy mid-run", 64'(busy), 64'd1);
    opA = 32'hAAAA_AAAA; opB = 32'h5555_5555; signedMode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R4 queue drained", 64'(expQ.size()), 64'd0);
    check({hi, lo} == 64'd77000, "R4 product kept", {hi, lo}, 64'd77000);

    // R5: hold while idle with changing operand inputs
    held = {hi, lo};
    opA = 32'h0F0F_0F0F; opB = 32'h1111_1111; signedMode = 1'b0;
    repeat (10) @(negedge clk);
    check({hi, lo} == held, "R5 hold", {hi, lo}, held);
    check(done == 1'b0, "R5 no done while idle", 64'(done), 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule